// File: doc/BRIEF.md
# Interrupt Coalescing Timer Unit

This unit gathers the completion and error events of a 10/100 network controller into one interrupt line. Ten event sources each own a bit of a status register, and a mask register with the same layout selects which bits can raise the line. The host clears a status bit by writing a one to it.

Two sources get special handling: receive-done (bit 0) and transmit-done (bit 4). Each of these paths counts its events against a programmable threshold, so several completions produce a single status set. Each path also has an optional timeout. The timeout is measured in cycles of 512 or 8192 bit-time strobes. The strobe comes from the MAC and already runs at the rate of the selected line speed. Once an event is pending, the timeout makes sure a partly filled batch is still reported.

All eight remaining sources set their status bit directly. The host reaches the status, mask and control words through a small register port. Writes are synchronous, and reads are combinational on the address.

Top module: `irq_coalescer`

## Requirements
- R1: After reset the status and mask registers read 0, the control register reads 0x1010, and `irq_o` is low.
- R2: An event pulse on any source other than bits 0 and 4 sets its status bit, which is visible right after the clock edge that samples the pulse.
- R3: Writing address 0 clears each status bit whose data bit is 1. An event for the same bit in the same cycle wins, and the bit stays set.
- R4: `irq_o` is high exactly when some status bit and its mask bit are both 1. The mask is written at address 1 and reads back from address 1.
- R5: Receive-done events on bit 0 are counted. Status bit 0 sets at the edge where the count reaches the receive threshold held in control bits 6:4, and the count then restarts from zero. A threshold of 0 behaves as 1.
- R6: Transmit-done events on bit 4 are counted in the same way, against the threshold in control bits 14:12.
- R7: The receive timeout sits in control bits 3:0 and the transmit timeout in bits 11:8, each a number of cycles n. While at least one event is pending, the status bit sets after n·L strobes, counted from the edge after the first pending event. L is 512 when the path's long select is 0 and 8192 when it is 1. The long select is control bit 7 for receive and bit 15 for transmit.
- R8: A timeout of 0 disables the timeout, and pending events are held until the threshold is reached.
- R9: The timeout advances only on clock edges where `bit_stb_i` is high.
- R10: The control register is written at address 2 and reads back all 16 bits. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| evt_i | input | 10 | Single-cycle event pulses, one per status bit |
| bit_stb_i | input | 1 | One pulse per line bit time |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 2 | Register address: 0 status, 1 mask, 2 control |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
There is one register stage between every input and the state it affects. Direct events, clears, mask and control writes therefore all appear one edge after the inputs are driven. The bench drives inputs at the falling edge and reads back half a period after the next rising edge. A threshold hit shows up at the same edge as the event that completes the count. A timeout shows up exactly n·L strobe edges after the edge that made the path pending. For each timeout case the bench counts those edges, then checks that the bit is still clear one edge before the deadline and set at the deadline itself. Random traffic runs with threshold 1 and no timeout, and is compared each cycle against a bench model of the status and the interrupt.

// File: rtl/irq_coal_pkg.sv
package irq_coal_pkg;
    localparam int NUM_SRC      = 10;
    localparam int REG_W        = 16;
    localparam int ADDR_W       = 2;
    localparam int THR_W        = 3;
    localparam int TMO_W        = 4;
    localparam int NORM_STROBES = 512;
    localparam int LONG_STROBES = 8192;
    localparam int RX_DONE_BIT  = 0;
    localparam int TX_DONE_BIT  = 4;

    localparam logic [ADDR_W-1:0] ADDR_STATUS  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_MASK    = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_CONTROL = 2'd2;

    localparam logic [REG_W-1:0] CONTROL_RESET = 16'h1010;
endpackage

// File: rtl/irq_coal_timer.sv
module irq_coal_timer #(
    parameter int NORM_LEN = 512,
    parameter int LONG_LEN = 8192,
    parameter int TMO_W    = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic             stb_i,
    input  logic             long_i,
    input  logic [TMO_W-1:0] tmo_i,
    output logic             expire_o
);
    localparam int CNT_W = $clog2(LONG_LEN);

    typedef struct packed {
        logic [CNT_W-1:0] bits;
        logic [TMO_W-1:0] cyc;
    } tstate_t;

    tstate_t st_d, st_q;
    logic    last_bit;

    always_comb begin
        st_d     = st_q;
        last_bit = long_i ? (st_q.bits == CNT_W'(LONG_LEN - 1))
                          : (st_q.bits == CNT_W'(NORM_LEN - 1));
        expire_o = run_i && stb_i && (tmo_i != '0) && last_bit
                   && (st_q.cyc == tmo_i - TMO_W'(1));
        if (!run_i || restart_i) begin
            st_d = '0;
        end else if (stb_i) begin
            if (last_bit) begin
                st_d.bits = '0;
                st_d.cyc  = st_q.cyc + TMO_W'(1);
            end else begin
                st_d.bits = st_q.bits + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // R9: a strobe while running moves the timer
    assert_strobe_advances_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && stb_i && !restart_i) |=> (st_q != $past(st_q)));

    // R9: no strobe, no progress
    assert_hold_without_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && !stb_i && !restart_i) |=> $stable(st_q));
endmodule

// File: rtl/irq_coal_path.sv
module irq_coal_path #(
    parameter int THR_W    = 3,
    parameter int TMO_W    = 4,
    parameter int NORM_LEN = 512,
    parameter int LONG_LEN = 8192
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             evt_i,
    input  logic             stb_i,
    input  logic [THR_W-1:0] thr_i,
    input  logic [TMO_W-1:0] tmo_i,
    input  logic             long_i,
    output logic             set_o
);
    logic [THR_W-1:0] pending_d, pending_q;
    logic [THR_W:0]   sum;
    logic [THR_W-1:0] thr_eff;
    logic             hit;
    logic             expire;

    irq_coal_timer #(
        .NORM_LEN (NORM_LEN),
        .LONG_LEN (LONG_LEN),
        .TMO_W    (TMO_W)
    ) timer_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (pending_q != '0),
        .restart_i (set_o),
        .stb_i     (stb_i),
        .long_i    (long_i),
        .tmo_i     (tmo_i),
        .expire_o  (expire)
    );

    always_comb begin
        thr_eff   = (thr_i == '0) ? THR_W'(1) : thr_i;
        sum       = {1'b0, pending_q} + (THR_W + 1)'(evt_i);
        hit       = sum >= {1'b0, thr_eff};
        set_o     = hit || expire;
        pending_d = set_o ? '0 : sum[THR_W-1:0];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) pending_q <= '0;
        else         pending_q <= pending_d;
    end

    // R5: a report empties the batch
    assert_report_empties_batch_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_o |=> (pending_q == '0));

    // R7: the timer never reports an empty path
    assert_idle_no_report_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pending_q == '0 && !evt_i) |-> !set_o);
endmodule

// File: rtl/irq_coalescer.sv
module irq_coalescer
    import irq_coal_pkg::*;
#(
    parameter int NUM_SRC_P = NUM_SRC,
    parameter int REG_W_P   = REG_W
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NUM_SRC_P-1:0] evt_i,
    input  logic                 bit_stb_i,
    input  logic                 reg_we_i,
    input  logic [ADDR_W-1:0]    reg_addr_i,
    input  logic [REG_W_P-1:0]   reg_wdata_i,
    output logic [REG_W_P-1:0]   reg_rdata_o,
    output logic                 irq_o
);
    localparam int CFG_W  = 1 + THR_W + TMO_W;
    localparam int NPATH  = 2;
    localparam logic [NUM_SRC_P-1:0] COAL_MASK =
        (NUM_SRC_P'(1) << RX_DONE_BIT) | (NUM_SRC_P'(1) << TX_DONE_BIT);
    localparam logic [NUM_SRC_P-1:0] DIRECT_MASK = ~COAL_MASK;

    typedef struct packed {
        logic [NUM_SRC_P-1:0] status;
        logic [NUM_SRC_P-1:0] mask;
        logic [REG_W_P-1:0]   ctrl;
    } regs_t;

    regs_t                r_d, r_q;
    logic [NPATH-1:0]     path_evt;
    logic [NPATH-1:0]     path_set;
    logic [NUM_SRC_P-1:0] coal_set;
    logic [NUM_SRC_P-1:0] clr;

    assign path_evt[0] = evt_i[RX_DONE_BIT];
    assign path_evt[1] = evt_i[TX_DONE_BIT];

    for (genvar p = 0; p < NPATH; p++) begin : g_path
        irq_coal_path #(
            .THR_W    (THR_W),
            .TMO_W    (TMO_W),
            .NORM_LEN (NORM_STROBES),
            .LONG_LEN (LONG_STROBES)
        ) path_i (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .evt_i  (path_evt[p]),
            .stb_i  (bit_stb_i),
            .thr_i  (r_q.ctrl[p*CFG_W + TMO_W +: THR_W]),
            .tmo_i  (r_q.ctrl[p*CFG_W +: TMO_W]),
            .long_i (r_q.ctrl[p*CFG_W + CFG_W - 1]),
            .set_o  (path_set[p])
        );
    end

    always_comb begin
        r_d                   = r_q;
        coal_set              = '0;
        coal_set[RX_DONE_BIT] = path_set[0];
        coal_set[TX_DONE_BIT] = path_set[1];
        clr = (reg_we_i && reg_addr_i == ADDR_STATUS) ? reg_wdata_i[NUM_SRC_P-1:0] : '0;
        r_d.status = (r_q.status & ~clr) | (evt_i & DIRECT_MASK) | coal_set;
        if (reg_we_i && reg_addr_i == ADDR_MASK)    r_d.mask = reg_wdata_i[NUM_SRC_P-1:0];
        if (reg_we_i && reg_addr_i == ADDR_CONTROL) r_d.ctrl = reg_wdata_i;

        case (reg_addr_i)
            ADDR_STATUS:  reg_rdata_o = REG_W_P'(r_q.status);
            ADDR_MASK:    reg_rdata_o = REG_W_P'(r_q.mask);
            ADDR_CONTROL: reg_rdata_o = r_q.ctrl;
            default:      reg_rdata_o = '0;
        endcase
        irq_o = |(r_q.status & r_q.mask);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q.status <= '0;
            r_q.mask   <= '0;
            r_q.ctrl   <= CONTROL_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    // R2: a direct event is captured at the next edge
    assert_direct_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((evt_i & DIRECT_MASK) != '0) |=>
        ((r_q.status & $past(evt_i & DIRECT_MASK)) == $past(evt_i & DIRECT_MASK)));

    // R3: a write-one clear without a competing event takes effect
    assert_clear_applies_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_we_i && reg_addr_i == ADDR_STATUS
         && ((reg_wdata_i[NUM_SRC_P-1:0] & DIRECT_MASK & ~evt_i) != '0)) |=>
        ((r_q.status & $past(reg_wdata_i[NUM_SRC_P-1:0] & DIRECT_MASK & ~evt_i)) == '0));

    // R4: an unmasked direct event raises the line
    assert_unmasked_event_raises_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (((evt_i & r_q.mask & DIRECT_MASK) != '0)
         && !(reg_we_i && reg_addr_i == ADDR_MASK)) |=> irq_o);

    // R4: nothing unmasked, no interrupt
    assert_mask_blocks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.mask == '0) |-> !irq_o);
endmodule

// File: tb/irq_coalescer_tb_top.sv
`timescale 1ns/100ps
module irq_coalescer_tb_top;
    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic [9:0]  evt_i = '0;
    logic        bit_stb_i = 1'b0;
    logic        reg_we_i = 1'b0;
    logic [1:0]  reg_addr_i = '0;
    logic [15:0] reg_wdata_i = '0;
    logic [15:0] reg_rdata_o;
    logic        irq_o;

    int  n_checks = 0;
    int  n_errors = 0;
    int  wd_cnt   = 0;
    logic stb_lvl = 1'b1;

    always #2 clk = ~clk;

    irq_coalescer dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_ni),
        .evt_i       (evt_i),
        .bit_stb_i   (bit_stb_i),
        .reg_we_i    (reg_we_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .irq_o       (irq_o)
    );

    function automatic logic [9:0] model_status(input logic [9:0] cur, input logic [9:0] ev,
                                                input logic [9:0] clr);
        return (cur & ~clr) | ev;
    endfunction

    function automatic logic model_irq(input logic [9:0] st, input logic [9:0] mk);
        return |(st & mk);
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic [9:0] ev, input logic we, input logic [1:0] ad,
                       input logic [15:0] wd);
        @(negedge clk);
        evt_i = ev; reg_we_i = we; reg_addr_i = ad; reg_wdata_i = wd; bit_stb_i = stb_lvl;
        @(posedge clk);
        #0.5;
        evt_i = '0; reg_we_i = 1'b0; reg_addr_i = 2'd0;
        #0.5;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc('0, 1'b0, 2'd0, '0);
    endtask

    task automatic rd(input logic [1:0] ad, output logic [15:0] d);
        reg_addr_i = ad;
        #0.2;
        d = reg_rdata_o;
        reg_addr_i = 2'd0;
        #0.2;
    endtask

    task automatic clear_all();
        cyc('0, 1'b1, 2'd0, 16'h03ff);
    endtask

    always @(posedge clk) begin
        wd_cnt++;
        if (wd_cnt > 150000) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", wd_cnt);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic [9:0]  m_st, m_mk;
        void'($urandom(32'h5eed));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_ni = 1'b1;
        #0.5;

        // R1 reset values
        rd(2'd0, d); chk("R1 status", d, 16'h0000);
        rd(2'd1, d); chk("R1 mask", d, 16'h0000);
        rd(2'd2, d); chk("R1 control", d, 16'h1010);
        chk("R1 irq", {15'd0, irq_o}, 16'h0);

        // R10 control readback, unused address
        cyc('0, 1'b1, 2'd2, 16'hA5C3);
        rd(2'd2, d); chk("R10 control readback", d, 16'hA5C3);
        rd(2'd3, d); chk("R10 addr3 zero", d, 16'h0000);

        // R2 direct source
        cyc('0, 1'b1, 2'd2, 16'h1010);
        cyc(10'h200, 1'b0, 2'd0, '0);
        rd(2'd0, d); chk("R2 direct bit9", d, 16'h0200);
        clear_all();

        // R5 rx threshold 3
        cyc('0, 1'b1, 2'd2, 16'h1030);
        cyc(10'h001, 1'b0, 2'd0, '0);
        cyc(10'h001, 1'b0, 2'd0, '0);
        rd(2'd0, d); chk("R5 below threshold", d, 16'h0000);
        cyc(10'h001, 1'b0, 2'd0, '0);
        rd(2'd0, d); chk("R5 threshold reached", d, 16'h0001);
        clear_all();

        // R5 threshold 0 acts as 1
        cyc('0, 1'b1, 2'd2, 16'h1000);
        cyc(10'h001, 1'b0, 2'd0, '0);
        rd(2'd0, d); chk("R5 threshold zero", d, 16'h0001);
        clear_all();

        // R6 tx threshold 2
        cyc('0, 1'b1, 2'd2, 16'h2010);
        cyc(10'h010, 1'b0, 2'd0, '0);
        rd(2'd0, d); chk("R6 below threshold", d, 16'h0000);
        cyc(10'h010, 1'b0, 2'd0, '0);
        rd(2'd0, d); chk("R6 threshold reached", d, 16'h0010);
        clear_all();

        // R7 rx timeout 1 normal cycle = 512 strobes
        cyc('0, 1'b1, 2'd2, 16'h1071);
        stb_lvl = 1'b1;
        cyc(10'h001, 1'b0, 2'd0, '0);
        idle(511);
        rd(2'd0, d); chk("R7 rx before timeout", d, 16'h0000);
        idle(1);
        rd(2'd0, d); chk("R7 rx at timeout", d, 16'h0001);
        clear_all();

        // R7 tx timeout 2 long cycles = 16384 strobes
        cyc('0, 1'b1, 2'd2, 16'hF210);
        cyc(10'h010, 1'b0, 2'd0, '0);
        idle(16383);
        rd(2'd0, d); chk("R7 tx long before timeout", d, 16'h0000);
        idle(1);
        rd(2'd0, d); chk("R7 tx long at timeout", d, 16'h0010);
        clear_all();

        // R9 strobe gating
        cyc('0, 1'b1, 2'd2, 16'h1071);
        stb_lvl = 1'b0;
        cyc(10'h001, 1'b0, 2'd0, '0);
        idle(1000);
        rd(2'd0, d); chk("R9 no strobes no timeout", d, 16'h0000);
        stb_lvl = 1'b1;
        idle(511);
        rd(2'd0, d); chk("R9 before timeout", d, 16'h0000);
        idle(1);
        rd(2'd0, d); chk("R9 at timeout", d, 16'h0001);
        clear_all();

        // R8 timeout 0 holds pending
        cyc('0, 1'b1, 2'd2, 16'h1070);
        cyc(10'h001, 1'b0, 2'd0, '0);
        idle(9000);
        rd(2'd0, d); chk("R8 no timeout", d, 16'h0000);
        for (int i = 0; i < 5; i++) cyc(10'h001, 1'b0, 2'd0, '0);
        rd(2'd0, d); chk("R8 six pending", d, 16'h0000);
        cyc(10'h001, 1'b0, 2'd0, '0);
        rd(2'd0, d); chk("R8 seventh reaches threshold", d, 16'h0001);
        clear_all();

        // R3 clear versus event race, R4 mask
        cyc('0, 1'b1, 2'd2, 16'h1010);
        cyc(10'h002, 1'b0, 2'd0, '0);
        cyc(10'h002, 1'b1, 2'd0, 16'h0002);
        rd(2'd0, d); chk("R3 event wins over clear", d, 16'h0002);
        chk("R4 masked no irq", {15'd0, irq_o}, 16'h0);
        cyc('0, 1'b1, 2'd1, 16'h0002);
        rd(2'd1, d); chk("R4 mask readback", d, 16'h0002);
        chk("R4 unmasked irq", {15'd0, irq_o}, 16'h1);
        cyc('0, 1'b1, 2'd0, 16'h0002);
        rd(2'd0, d); chk("R3 clear applies", d, 16'h0000);
        chk("R4 irq drops", {15'd0, irq_o}, 16'h0);

        // random traffic, threshold 1, no timeout: R2 R3 R4 R5 R6
        cyc('0, 1'b1, 2'd1, 16'h0000);
        clear_all();
        m_st = '0; m_mk = '0;
        for (int i = 0; i < 400; i++) begin
            logic [9:0]  ev;
            logic [15:0] wd;
            int          op;
            ev = 10'($urandom & $urandom & $urandom);
            wd = 16'($urandom);
            op = int'($urandom % 4);
            if (op == 0) begin
                cyc(ev, 1'b1, 2'd0, wd);
                m_st = model_status(m_st, ev, wd[9:0]);
            end else if (op == 1) begin
                cyc(ev, 1'b1, 2'd1, wd);
                m_st = model_status(m_st, ev, '0);
                m_mk = wd[9:0];
            end else begin
                cyc(ev, 1'b0, 2'd0, wd);
                m_st = model_status(m_st, ev, '0);
            end
            rd(2'd0, d); chk("R3 random status", d, {6'd0, m_st});
            chk("R4 random irq", {15'd0, irq_o}, {15'd0, model_irq(m_st, m_mk)});
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule